// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words while acting as the clock master of the link. When reception is armed, it drives a shift clock on `sclk_o` at a programmable rate. It samples `sdata_i` once per bit and assembles 8-bit words, or 9-bit words when the wide-word mode is selected. Completed words go into a small receive FIFO. The FIFO head is visible on the data and ninth-bit outputs, and a read strobe removes it.

Two enables arm the receiver. A single-word request receives one word and then clears itself. A continuous enable receives words back to back for as long as it stays high. When both are active, the continuous enable governs. If a word completes while the FIFO is full, the word is lost, an overrun error latches and reception halts. The only way to clear that error is a high-to-low transition of the continuous enable. A receive interrupt request follows the receive-complete flag and is gated by an interrupt enable.

Top module: `sync_master_rx`

## Requirements
- R1: After reset, `sclk_o`, `rx_done_o`, `irq_o`, `ovr_err_o` and `single_busy_o` are all 0.
- R2: While armed, `sclk_o` has a period of 4 × (`baud_div_i` + 1) clock cycles: half low, half high. It starts low and rests low when not armed.
- R3: `sdata_i` is sampled on each falling transition of `sclk_o`. The first sampled bit is bit 0 of the word (LSB first).
- R4: A pulse on `single_set_i` sets `single_busy_o`. Exactly one word is then received, after which `single_busy_o` returns to 0 and `sclk_o` stops.
- R5: While `cont_en_i` is high, words are received back to back. Clearing it stops the clock and discards any partly received word.
- R6: With both the single request and `cont_en_i` active, reception continues past the first word. `single_busy_o` still clears when that first word completes.
- R7: With `nine_bit_i`=1, words are 9 bits long. Bit 8 appears on `rx_bit8_o` and bits 7..0 appear on `rx_data_o`. In 8-bit mode, `rx_bit8_o` reads 0.
- R8: Received words are held in a 2-entry FIFO in arrival order. `rx_done_o` is 1 while the FIFO holds a word. A pulse on `rd_pop_i` removes the head.
- R9: `irq_o` is 1 exactly when `rx_done_o` and `irq_en_i` are both 1.
- R10: If a word completes while the FIFO is full, that word is dropped, `ovr_err_o` sets and the shift clock stops until the error is cleared.
- R11: `ovr_err_o` is cleared only on a 1-to-0 transition of `cont_en_i`. Reading the FIFO does not clear it.
- R12: While `port_en_i` is 0, `sclk_o` stays low and no word is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| port_en_i | input | 1 | Serial port enabled as synchronous clock master |
| baud_div_i | input | BAUD_W | Rate divisor; bit period is 4 × (value + 1) cycles |
| nine_bit_i | input | 1 | Select 9-bit words |
| single_set_i | input | 1 | Pulse: request one word |
| cont_en_i | input | 1 | Continuous receive enable |
| irq_en_i | input | 1 | Receive interrupt enable |
| sdata_i | input | 1 | Serial data input |
| rd_pop_i | input | 1 | Read strobe; removes the FIFO head |
| sclk_o | output | 1 | Generated shift clock |
| rx_data_o | output | 8 | Low 8 bits of the FIFO head |
| rx_bit8_o | output | 1 | Ninth bit of the FIFO head |
| rx_done_o | output | 1 | Receive-complete flag (FIFO not empty) |
| irq_o | output | 1 | Receive interrupt request |
| ovr_err_o | output | 1 | Overrun error |
| single_busy_o | output | 1 | Single-word request pending |

## Verification
Reception is driven with alternating bit patterns (A5, 5A, 3C), with all-ones data, and with a word whose set bits sit at both ends (81). Together these show whether the bit order is LSB first and whether sampling is aligned to the falling clock edge. Nine-bit words are sent both with the top bit set and with it clear, which separates a ninth bit that is routed correctly from one that is stuck. The bench exercises single, continuous and combined enables. The combined case shows that the continuous enable wins: one word versus two. A third word is sent into a full FIFO to check that it is dropped, that the clock halts, and that the error survives reads but clears on the continuous-enable fall. The divisor is run at 0 and 1 to check that the measured clock period scales with it.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/srx_clkgen.sv
// Shift clock generator: a half period lasts 2*(div+1) cycles; the clock
// rests low and starts each armed interval with a low half.
module srx_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             fall_o
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;
  logic [CNT_W-1:0] half_last;
  logic             at_end;

  assign half_last = {div_i, 1'b1};
  assign at_end    = (cnt_q >= half_last);

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!run_i) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (at_end) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign sclk_o = ph_q;
  assign fall_o = run_i & ph_q & at_end;
endmodule

// File: rtl/srx_shift.sv
// Word assembler: stores the bit sampled at each falling shift-clock
// transition at the current bit index, LSB first.
module srx_shift
  import srx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  logic  sample_i,
  input  logic  sdata_i,
  input  logic  nine_i,
  output word_t word_o,
  output logic  done_o
);
  localparam int unsigned IDX_W = $clog2(WORD_W);

  word_t            sh_q, sh_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] last_idx;
  word_t            merged;

  assign last_idx = nine_i ? IDX_W'(WORD_W - 1) : IDX_W'(WORD_W - 2);
  assign merged   = sh_q | (word_t'(sdata_i) << idx_q);
  assign done_o   = run_i & sample_i & (idx_q == last_idx);
  assign word_o   = merged;

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    if (!run_i || done_o) begin
      sh_d  = '0;
      idx_d = '0;
    end else if (sample_i) begin
      sh_d  = merged;
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  word_t din_i,
  input  logic  pop_i,
  output word_t dout_o,
  output logic  empty_o,
  output logic  full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  word_t            mem_q [DEPTH];
  word_t            mem_d [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full_o | do_pop);
  assign dout_o  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = do_push ? bump(wr_q) : wr_q;
    rd_d  = do_pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign mem_d[g] = (do_push && wr_q == PTR_W'(g)) ? din_i : mem_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else         mem_q[g] <= mem_d[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
  import srx_pkg::*;
#(
  parameter int unsigned BAUD_W     = 8,
  parameter int unsigned FIFO_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_en_i,
  input  logic [BAUD_W-1:0] baud_div_i,
  input  logic              nine_bit_i,
  input  logic              single_set_i,
  input  logic              cont_en_i,
  input  logic              irq_en_i,
  input  logic              sdata_i,
  input  logic              rd_pop_i,
  output logic              sclk_o,
  output logic [7:0]        rx_data_o,
  output logic              rx_bit8_o,
  output logic              rx_done_o,
  output logic              irq_o,
  output logic              ovr_err_o,
  output logic              single_busy_o
);
  logic  single_q, single_d;
  logic  ovr_q, ovr_d;
  logic  cont_prev_q;
  logic  active, fall, word_done, push;
  logic  fifo_empty, fifo_full, pop_ok;
  word_t word, head;

  assign active = port_en_i & ~ovr_q & (cont_en_i | single_q);
  assign pop_ok = rd_pop_i & ~fifo_empty;
  assign push   = word_done & (~fifo_full | pop_ok);

  srx_clkgen #(.DIV_W(BAUD_W)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .div_i  (baud_div_i),
    .sclk_o (sclk_o),
    .fall_o (fall)
  );

  srx_shift u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (active),
    .sample_i (fall),
    .sdata_i  (sdata_i),
    .nine_i   (nine_bit_i),
    .word_o   (word),
    .done_o   (word_done)
  );

  srx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   (word),
    .pop_i   (rd_pop_i),
    .dout_o  (head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  always_comb begin
    single_d = single_q;
    if (single_set_i)   single_d = 1'b1;
    else if (word_done) single_d = 1'b0;

    ovr_d = ovr_q;
    if (cont_prev_q && !cont_en_i)                 ovr_d = 1'b0;
    else if (word_done && fifo_full && !pop_ok)    ovr_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_q    <= 1'b0;
      ovr_q       <= 1'b0;
      cont_prev_q <= 1'b0;
    end else begin
      single_q    <= single_d;
      ovr_q       <= ovr_d;
      cont_prev_q <= cont_en_i;
    end
  end

  assign rx_data_o     = head[7:0];
  assign rx_bit8_o     = head[8];
  assign rx_done_o     = ~fifo_empty;
  assign irq_o         = ~fifo_empty & irq_en_i;
  assign ovr_err_o     = ovr_q;
  assign single_busy_o = single_q;
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic port_en_i,
  input logic cont_en_i,
  input logic sclk_o,
  input logic rx_done_o,
  input logic irq_o,
  input logic ovr_err_o,
  input logic single_busy_o
);
  AST_PORT_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> !sclk_o); // R12
  AST_IRQ_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rx_done_o); // R9
  AST_OVERRUN_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_err_o |=> !sclk_o); // R10
  AST_ERR_CLEAR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovr_err_o) |-> ($past(cont_en_i, 2) && !$past(cont_en_i))); // R11
  AST_SINGLE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(single_busy_o) && !cont_en_i) |=> !sclk_o); // R4
endmodule

bind sync_master_rx srx_checker u_srx_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .port_en_i     (port_en_i),
  .cont_en_i     (cont_en_i),
  .sclk_o        (sclk_o),
  .rx_done_o     (rx_done_o),
  .irq_o         (irq_o),
  .ovr_err_o     (ovr_err_o),
  .single_busy_o (single_busy_o)
);

// File: tb/sync_master_rx_tb_top.sv
`timescale 1ns/1ps
module sync_master_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b0, nine = 1'b0, single_set = 1'b0, cont = 1'b0;
  logic       irq_en = 1'b0, sdata = 1'b0, rd_pop = 1'b0;
  logic [7:0] div = 8'd1;
  logic       sclk, bit8, done, irq, ovr, busy;
  logic [7:0] data;

  int total = 0, bad = 0;
  int rises = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;
  logic [8:0] txq[$];
  logic [8:0] expq[$];

  always #5 clk = ~clk;

  sync_master_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .baud_div_i(div),
    .nine_bit_i(nine), .single_set_i(single_set), .cont_en_i(cont),
    .irq_en_i(irq_en), .sdata_i(sdata), .rd_pop_i(rd_pop), .sclk_o(sclk),
    .rx_data_o(data), .rx_bit8_o(bit8), .rx_done_o(done), .irq_o(irq),
    .ovr_err_o(ovr), .single_busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // serial data source: next bit presented on each rising shift clock
  always @(posedge sclk) begin
    rises++;
    #1;
    if (txq.size() != 0) begin
      static int idx = 0;
      sdata = txq[0][idx];
      idx++;
      if (idx == (nine ? 9 : 8)) begin
        idx = 0;
        void'(txq.pop_front());
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rd_pop) rd_pop = 1'b0;
      else if (mon_en && done) begin
        if (expq.size() == 0) check(1'b0, "R8 unexpected word", {bit8, data}, 0);
        else begin
          logic [8:0] e;
          e = expq.pop_front();
          check({bit8, data} == e, "R3/R7 word", {bit8, data}, e);
        end
        rd_pop = 1'b1;
      end
    end
  end

  task automatic send(input logic [8:0] w, input bit expect_it);
    txq.push_back(w);
    if (expect_it) expq.push_back(w);
  endtask

  task automatic pulse_single();
    @(negedge clk) single_set = 1'b1;
    @(negedge clk) single_set = 1'b0;
  endtask

  task automatic man_pop();
    @(negedge clk) rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
  endtask

  task automatic measure(input int want, input string req);
    realtime t0, t1;
    @(posedge sclk) t0 = $realtime;
    @(posedge sclk) t1 = $realtime;
    check(int'((t1 - t0) / 10.0) == want, req, int'((t1 - t0) / 10.0), want);
  endtask

  task automatic stop_cont_after_tx();
    wait (txq.size() == 0);
    @(negedge sclk);
    @(negedge clk) cont = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    begin : wd
      #1_000_000;
      if (!finished) begin
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int r0;
    idle(3);
    // R1 reset state
    check(sclk == 0, "R1 sclk", sclk, 0);
    check(done == 0, "R1 done", done, 0);
    check(irq == 0 && ovr == 0 && busy == 0, "R1 irq/ovr/busy", {irq, ovr, busy}, 0);
    @(negedge clk) rst_n = 1'b1;
    mon_en = 1'b1;

    // R12 port disabled: armed request does nothing
    pulse_single();
    r0 = rises;
    idle(60);
    check(rises == r0 && done == 0, "R12 no clock while port off", rises - r0, 0);

    // R4 single word, R2 period at div=1
    send(9'h0A5, 1'b1);
    @(negedge clk) port_en = 1'b1;
    measure(8, "R2 period div=1");
    wait (busy == 0);
    idle(4);
    check(busy == 0, "R4 single clears", busy, 0);
    r0 = rises;
    idle(50);
    check(rises == r0, "R4 clock stops after one word", rises - r0, 0);
    check(expq.size() == 0, "R3 single word received", expq.size(), 0);

    // R5 continuous, R2 at div=0
    @(negedge clk) div = 8'd0;
    send(9'h03C, 1'b1); send(9'h081, 1'b1); send(9'h0FF, 1'b1);
    @(negedge clk) cont = 1'b1;
    measure(4, "R2 period div=0");
    stop_cont_after_tx();
    idle(20);
    check(expq.size() == 0, "R5 three words back to back", expq.size(), 0);
    r0 = rises;
    idle(40);
    check(rises == r0 && done == 0, "R5 stops when cleared", rises - r0, 0);

    // R7 nine-bit words
    @(negedge clk) nine = 1'b1;
    send(9'h1A5, 1'b1); send(9'h0F3, 1'b1);
    @(negedge clk) cont = 1'b1;
    stop_cont_after_tx();
    idle(20);
    check(expq.size() == 0, "R7 nine-bit words", expq.size(), 0);
    @(negedge clk) nine = 1'b0;

    // R8 FIFO order, R9 interrupt gating
    mon_en = 1'b0;
    send(9'h05A, 1'b0);
    pulse_single();
    wait (busy == 0);
    idle(2);
    check(done == 1 && irq == 0, "R9 irq masked", {done, irq}, 2);
    @(negedge clk) irq_en = 1'b1;
    #1 check(irq == 1, "R9 irq raised", irq, 1);
    send(9'h077, 1'b0);
    pulse_single();
    wait (busy == 0);
    idle(2);
    check({bit8, data} == 9'h05A, "R8 head is oldest", {bit8, data}, 9'h05A);
    man_pop();
    check({bit8, data} == 9'h077 && done == 1, "R8 second entry", {bit8, data}, 9'h077);
    man_pop();
    check(done == 0 && irq == 0, "R8/R9 empty after pops", {done, irq}, 0);
    @(negedge clk) irq_en = 1'b0;

    // R6 both enables: continuous wins
    mon_en = 1'b1;
    send(9'h0C3, 1'b1); send(9'h01E, 1'b1);
    @(negedge clk) begin single_set = 1'b1; cont = 1'b1; end
    @(negedge clk) single_set = 1'b0;
    stop_cont_after_tx();
    idle(20);
    check(expq.size() == 0, "R6 two words with both enables", expq.size(), 0);
    check(busy == 0, "R6 single cleared", busy, 0);

    // R10 overrun, R11 clearing
    mon_en = 1'b0;
    send(9'h011, 1'b0); send(9'h022, 1'b0); send(9'h033, 1'b0);
    @(negedge clk) cont = 1'b1;
    wait (txq.size() == 0);
    @(negedge sclk);
    @(negedge clk);
    check(ovr == 1, "R10 overrun set", ovr, 1);
    r0 = rises;
    idle(40);
    check(rises == r0, "R10 clock halted", rises - r0, 0);
    check({bit8, data} == 9'h011, "R10 first kept", {bit8, data}, 9'h011);
    man_pop();
    check({bit8, data} == 9'h022, "R10 second kept", {bit8, data}, 9'h022);
    man_pop();
    check(done == 0, "R10 third dropped", done, 0);
    check(ovr == 1, "R11 reads do not clear", ovr, 1);
    @(negedge clk) cont = 1'b0;
    idle(2);
    check(ovr == 0, "R11 cleared by cont fall", ovr, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule